// File: doc/BRIEF.md
# DTMF Receive Qualifier

This block sits behind a tone detector that raises a per-sample "tone present" flag together with a 4-bit decoded key code. It decides when a tone counts as a real key press and presents the result to a host as a held code register and a strobe. Timing is counted in a millisecond tick. Bursts too short to qualify are discarded, short dropouts are bridged, and the code is held until a long enough silence. The strobe follows the code by a small delay, so a host can latch the code on the strobe's active edge.

Two timing profiles are provided: a normal one and a fast one with shorter windows. Each window length is a parameter counted in ticks. The profile input is sampled once, when a new reception starts, and it governs that reception until it ends. The detector inputs are plain levels that are sampled on every clock. There is no handshake and no back-pressure: the block never stalls the detector, and the host must take the code while the strobe is active.

Top module: `dtmf_rx_qualifier`

## Requirements
- R1: After reset, `rx_code` is 0 and `strobe_n` is 1.
- R2: A tone seen on fewer than the accept count of ticks, followed by a silence of the first-gap count of ticks, leaves `rx_code` at 0 and `strobe_n` at 1.
- R3: When the accept count of ticks with the tone present has been reached, `rx_code` takes the `tone_code` value sampled at that tick. It is visible from the next clock, and `strobe_n` is still 1 at that point.
- R4: `strobe_n` goes to 0 (active) exactly the strobe-delay count of ticks after `rx_code` was loaded.
- R5: Before the strobe is active, a run of consecutive silent ticks shorter than the first-gap count does not restart qualification, because ticks with the tone present keep accumulating. A run that reaches the first-gap count abandons the attempt and discards the accumulated count.
- R6: While the strobe is active, a run of consecutive silent ticks shorter than the second-gap count clears neither `rx_code` nor the strobe.
- R7: A run of consecutive silent ticks that reaches the second-gap count clears `rx_code` to 0 and returns `strobe_n` to 1 on the same clock edge.
- R8: While the strobe is active, a change of `tone_code` leaves `rx_code` unchanged.
- R9: When `fast_sel` is 1 at the clock where a reception starts, the fast counts apply. A later change of `fast_sel` has no effect until that reception ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ms_tick | input | 1 | One-clock pulse, once per millisecond |
| fast_sel | input | 1 | 1 selects the fast timing profile |
| tone_valid | input | 1 | Detector reports a valid tone pair in this sample |
| tone_code | input | 4 | Detector's decoded key code |
| rx_code | output | 4 | Qualified key code, 0 when idle |
| strobe_n | output | 1 | Active-low strobe, follows `rx_code` |

## Verification
The assertions take `ms_tick` to be a single-clock pulse, and they take every window count to be at least 1. The timing profile must not change in the middle of a reception. They also take the four timing counts to fit the counter width. The bench drives the tick as one clock out of every four, and it picks small nonzero counts for both profiles. It changes the detector inputs only on the falling clock edge right after a tick, so each tone and each gap spans an exact number of ticks. The bench changes `fast_sel` in the middle of a reception only to show that the change is ignored.

// File: rtl/dtq_pkg.sv
package dtq_pkg;
  localparam int TW = 8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_QUALIFY, ST_OUTPUT_DATA, ST_STROBE, ST_HOLD_GAP, ST_CLEAR
  } dtq_state_e;

  typedef struct packed {
    logic [TW-1:0] accept;
    logic [TW-1:0] gap1;
    logic [TW-1:0] sp_delay;
    logic [TW-1:0] gap2;
  } dtq_timing_t;
endpackage

// File: rtl/dtq_profile_mux.sv
module dtq_profile_mux
  import dtq_pkg::*;
#(
  parameter int ACC_N = 40, parameter int GAP1_N = 20,
  parameter int SPD_N = 1,  parameter int GAP2_N = 30,
  parameter int ACC_F = 25, parameter int GAP1_F = 10,
  parameter int SPD_F = 1,  parameter int GAP2_F = 20
) (
  input  logic        prof_fast,
  output dtq_timing_t lim
);
  localparam dtq_timing_t NORM = '{TW'(ACC_N), TW'(GAP1_N), TW'(SPD_N), TW'(GAP2_N)};
  localparam dtq_timing_t FAST = '{TW'(ACC_F), TW'(GAP1_F), TW'(SPD_F), TW'(GAP2_F)};

  assign lim = prof_fast ? FAST : NORM;
endmodule

// File: rtl/dtq_ctrl.sv
module dtq_ctrl
  import dtq_pkg::*;
#(
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ms_tick,
  input  logic              fast_sel,
  input  logic              tone_valid,
  input  logic [CODE_W-1:0] tone_code,
  input  dtq_timing_t       lim,
  output logic              prof_q,
  output logic [CODE_W-1:0] rx_code,
  output logic              strobe
);
  dtq_state_e    state;
  logic [TW-1:0] on_cnt, off_cnt;
  logic [TW-1:0] on_inc, off_inc;

  assign on_inc  = on_cnt + 1'b1;
  assign off_inc = off_cnt + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      on_cnt  <= '0;
      off_cnt <= '0;
      prof_q  <= 1'b0;
      rx_code <= '0;
      strobe  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (tone_valid) begin
          state   <= ST_QUALIFY;
          on_cnt  <= '0;
          off_cnt <= '0;
          prof_q  <= fast_sel;
        end
        ST_QUALIFY: if (ms_tick) begin
          if (tone_valid) begin
            off_cnt <= '0;
            if (on_inc == lim.accept) begin
              rx_code <= tone_code;
              on_cnt  <= '0;
              state   <= ST_OUTPUT_DATA;
            end else begin
              on_cnt <= on_inc;
            end
          end else if (off_inc == lim.gap1) begin
            state <= ST_IDLE;
          end else begin
            off_cnt <= off_inc;
          end
        end
        ST_OUTPUT_DATA: if (ms_tick) begin
          if (on_inc == lim.sp_delay) begin
            strobe  <= 1'b1;
            off_cnt <= '0;
            state   <= ST_STROBE;
          end else begin
            on_cnt <= on_inc;
          end
        end
        ST_STROBE, ST_HOLD_GAP: if (ms_tick) begin
          if (tone_valid) begin
            off_cnt <= '0;
            state   <= ST_STROBE;
          end else if (off_inc == lim.gap2) begin
            rx_code <= '0;
            strobe  <= 1'b0;
            state   <= ST_CLEAR;
          end else begin
            off_cnt <= off_inc;
            state   <= ST_HOLD_GAP;
          end
        end
        ST_CLEAR: state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  // R4
  strobe_after_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(strobe) |-> ($past(ms_tick) && $past(state == ST_OUTPUT_DATA)));

  // R6
  gap2_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HOLD_GAP) |-> (off_cnt != '0 && off_cnt < lim.gap2 && strobe));

  // R7
  clear_together_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(strobe) |-> (rx_code == '0));

  // R8
  code_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && $past(strobe)) |-> $stable(rx_code));

  // R9
  profile_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE && $past(state != ST_IDLE)) |-> $stable(prof_q));
endmodule

// File: rtl/dtmf_rx_qualifier.sv
module dtmf_rx_qualifier
  import dtq_pkg::*;
#(
  parameter int CODE_W = 4,
  parameter int ACC_N = 40, parameter int GAP1_N = 20,
  parameter int SPD_N = 1,  parameter int GAP2_N = 30,
  parameter int ACC_F = 25, parameter int GAP1_F = 10,
  parameter int SPD_F = 1,  parameter int GAP2_F = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ms_tick,
  input  logic              fast_sel,
  input  logic              tone_valid,
  input  logic [CODE_W-1:0] tone_code,
  output logic [CODE_W-1:0] rx_code,
  output logic              strobe_n
);
  dtq_timing_t lim;
  logic        prof_q;
  logic        strobe;

  dtq_profile_mux #(
    .ACC_N(ACC_N), .GAP1_N(GAP1_N), .SPD_N(SPD_N), .GAP2_N(GAP2_N),
    .ACC_F(ACC_F), .GAP1_F(GAP1_F), .SPD_F(SPD_F), .GAP2_F(GAP2_F)
  ) u_prof (
    .prof_fast(prof_q),
    .lim      (lim)
  );

  dtq_ctrl #(.CODE_W(CODE_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .ms_tick   (ms_tick),
    .fast_sel  (fast_sel),
    .tone_valid(tone_valid),
    .tone_code (tone_code),
    .lim       (lim),
    .prof_q    (prof_q),
    .rx_code   (rx_code),
    .strobe    (strobe)
  );

  assign strobe_n = ~strobe;

  // R1
  idle_after_reset_chk: assert property (@(posedge clk)
    $past(!rst_n) |-> (rx_code == '0 && strobe_n));
endmodule

// File: tb/dtmf_rx_qualifier_bench.sv
module dtmf_rx_qualifier_bench;
  localparam int AN = 6, G1N = 3, SN = 1, G2N = 5;
  localparam int AF = 3, G1F = 2, SF = 2, G2F = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ms_tick = 1'b0;
  logic       fast_sel = 1'b0;
  logic       tone_valid = 1'b0;
  logic [3:0] tone_code = 4'h0;
  logic [3:0] rx_code;
  logic       strobe_n;

  int tests = 0, fails = 0, div = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dtmf_rx_qualifier #(
    .ACC_N(AN), .GAP1_N(G1N), .SPD_N(SN), .GAP2_N(G2N),
    .ACC_F(AF), .GAP1_F(G1F), .SPD_F(SF), .GAP2_F(G2F)
  ) u_dtmf_rx_qualifier (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .fast_sel(fast_sel),
    .tone_valid(tone_valid), .tone_code(tone_code),
    .rx_code(rx_code), .strobe_n(strobe_n)
  );

  always @(negedge clk) begin
    div     <= (div == 3) ? 0 : div + 1;
    ms_tick <= (div == 3);
  end

  // behavioural reference: phase 0 idle, 1 qualifying, 2 code shown, 3 strobing, 4 clearing
  int phase = 0, n_on = 0, n_off = 0, m_acc, m_g1, m_sd, m_g2;
  logic [3:0] m_code = 4'h0;
  bit m_stb = 1'b0;

  always @(posedge clk) begin
    if (!rst_n) begin
      phase = 0; m_code = 4'h0; m_stb = 1'b0;
    end else begin
      case (phase)
        0: if (tone_valid) begin
          phase = 1; n_on = 0; n_off = 0;
          m_acc = fast_sel ? AF : AN;  m_g1 = fast_sel ? G1F : G1N;
          m_sd  = fast_sel ? SF : SN;  m_g2 = fast_sel ? G2F : G2N;
        end
        1: if (ms_tick) begin
          if (tone_valid) begin
            n_off = 0; n_on++;
            if (n_on == m_acc) begin m_code = tone_code; phase = 2; n_on = 0; end
          end else begin
            n_off++;
            if (n_off == m_g1) phase = 0;
          end
        end
        2: if (ms_tick) begin
          n_on++;
          if (n_on == m_sd) begin m_stb = 1'b1; phase = 3; n_off = 0; end
        end
        3: if (ms_tick) begin
          if (tone_valid) n_off = 0;
          else begin
            n_off++;
            if (n_off == m_g2) begin m_code = 4'h0; m_stb = 1'b0; phase = 4; end
          end
        end
        default: phase = 0;
      endcase
    end
  end

  always @(negedge clk) if (rst_n && !done) begin
    tests++;
    if (rx_code !== m_code || strobe_n !== !m_stb) begin
      fails++;
      $display("FAIL model R3/R4/R6/R7: t=%0t rx_code=%h strobe_n=%b expected %h %b",
               $time, rx_code, strobe_n, m_code, !m_stb);
    end
  end

  task automatic check(string req, int act, int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // hold the detector inputs for n ticks, then release just after the last tick
  task automatic drive(bit v, logic [3:0] c, int n);
    tone_valid = v; tone_code = c;
    for (int i = 0; i < n; i++) @(posedge clk iff ms_tick);
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 code", rx_code, 0);
    check("R1 strobe_n", strobe_n, 1);
    rst_n = 1'b1;
    @(posedge clk iff ms_tick); @(negedge clk);

    // R2: too short a burst, then a silence long enough to abandon it
    drive(1, 4'h5, AN - 1);
    drive(0, 4'h0, G1N);
    check("R2 code", rx_code, 0);
    check("R2 strobe_n", strobe_n, 1);

    // R3 and R4
    drive(1, 4'h9, AN);
    check("R3 code", rx_code, 9);
    check("R3 strobe_n still idle", strobe_n, 1);
    drive(1, 4'h9, SN);
    check("R4 strobe_n", strobe_n, 0);

    // R6 and R8: short gap, then a different code
    drive(0, 4'h0, G2N - 1);
    check("R6 strobe_n after short gap", strobe_n, 0);
    check("R6 code after short gap", rx_code, 9);
    drive(1, 4'h3, 2);
    check("R8 code kept", rx_code, 9);
    check("R8 strobe_n", strobe_n, 0);

    // R7: full-length gap
    drive(0, 4'h0, G2N - 1);
    check("R7 before limit", strobe_n, 0);
    drive(0, 4'h0, 1);
    check("R7 code cleared", rx_code, 0);
    check("R7 strobe_n released", strobe_n, 1);

    // R5: bridged gap before acceptance
    drive(1, 4'h2, 2);
    drive(0, 4'h0, G1N - 1);
    drive(1, 4'h2, AN - 2);
    check("R5 bridged code", rx_code, 2);
    drive(1, 4'h2, SN);
    drive(0, 4'h0, G2N);
    check("R5 cleared", rx_code, 0);

    // R5: a gap reaching the limit discards the partial count
    drive(1, 4'h7, 2);
    drive(0, 4'h0, G1N);
    drive(1, 4'h7, AN - 2);
    check("R5 restart code", rx_code, 0);
    drive(0, 4'h0, G1N);

    // R9: fast profile latched at start
    fast_sel = 1'b1;
    drive(1, 4'hC, AF);
    check("R9 fast accept", rx_code, 12);
    fast_sel = 1'b0;
    drive(1, 4'hC, SF - 1);
    check("R9 fast delay not yet", strobe_n, 1);
    drive(1, 4'hC, 1);
    check("R9 fast strobe", strobe_n, 0);
    drive(0, 4'h0, G2F);
    check("R9 fast clear", rx_code, 0);
    check("R9 fast clear strobe_n", strobe_n, 1);

    // R9: normal profile needs the longer count
    drive(1, 4'h4, AF);
    check("R9 normal not yet", rx_code, 0);
    drive(1, 4'h4, AN - AF);
    check("R9 normal accept", rx_code, 4);
    drive(0, 4'h0, G2N + 2);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule